// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides an incoming clock by an integer from 1 to 32. Outside bypass, the divided clock is made of two phases. The high phase lasts `hi_cnt + 1` input cycles and the low phase lasts `lo_cnt + 1` input cycles, so one output period is `hi_cnt + lo_cnt + 2` input cycles. With 4-bit fields this covers every ratio from 2 to 32. Any split of the period between the two phases is allowed. A bypass control gives the ratio of 1 by passing the input clock straight to the output.

Odd ratios can be balanced to a 50% duty cycle. This needs the correction enable set and `lo_cnt = hi_cnt + 1`. A flop clocked on the falling input edge then stretches the high phase by half an input cycle. After each restart, the output can hold its idle level for a delay of 0 to 15 input cycles. It then opens with either the high phase or the low phase, as selected.

All settings are sampled together at one edge only: the first rising edge after reset is released, or a rising edge with `sync` high. At any other time, changes on the setting inputs have no effect. Pulsing `sync` on several copies of the block restarts them all at the same edge, which aligns their outputs.

The sequencer has four states:
- LOAD: entered on reset.
- DELAY: counts down the start offset.
- HIGH: the high phase.
- LOW: the low phase.

Its transitions are:
- CAPTURE: from LOAD, or from any state when `sync` is high. It goes to DELAY when the offset is non-zero. Otherwise it goes straight to the starting phase.
- LAUNCH: DELAY to the starting phase, when the delay count reaches zero.
- FALL: HIGH to LOW, when the high count reaches zero.
- RISE: LOW to HIGH, when the low count reaches zero.

Top module: `clkdiv_duty`

## Requirements
- R1: Outside bypass, after the start offset, `clk_out` is high for `hi_cnt+1` input cycles and low for `lo_cnt+1` input cycles, repeating. The period is `hi_cnt+lo_cnt+2` input cycles, and any split is allowed.
- R2: With bypass captured as 1, `clk_out` equals `clk_in`. The correction, offset and start-level settings then have no effect.
- R3: With the correction enable captured as 1 and `lo_cnt = hi_cnt+1`, every high stretch of `clk_out` is extended by half an input cycle past the rising edge that ends it. The result is equal high and low times.
- R4: With the correction enable at 0, or `lo_cnt != hi_cnt+1`, `clk_out` changes only just after rising edges of `clk_in`, with no half-cycle extension.
- R5: For `phase_ofs = K > 0`, `clk_out` holds the inverse of the start level for K input cycles after the capture edge, then begins the starting phase. For K = 0, the starting phase begins at the capture edge.
- R6: `start_hi = 1` makes the first phase HIGH, and `start_hi = 0` makes it LOW.
- R7: Settings are captured only at the first rising edge after reset release, or at a rising edge with `sync` = 1. Changes at other times leave `clk_out` unchanged.
- R8: While `rst_n` is low, `clk_out` is low (outside bypass), and asserting `rst_n` takes effect without waiting for a clock edge.
- R9: A `sync` pulse in the middle of a period restarts the sequence from the capture edge, with any new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Restart pulse; capture settings at this edge |
| hi_cnt | input | 4 | High phase length minus one |
| lo_cnt | input | 4 | Low phase length minus one |
| bypass | input | 1 | 1 selects divide-by-1 (output = input clock) |
| dcc_en | input | 1 | Half-cycle duty correction enable |
| phase_ofs | input | 4 | Start delay in input cycles |
| start_hi | input | 1 | 1: start with high phase; 0: start with low phase |
| clk_out | output | 1 | Divided clock |

## Verification
The hardest behaviour to reach is the half-cycle stretch. It appears only between a rising and a falling input edge, and only when correction is enabled and the low count is exactly one above the high count. The bench samples `clk_out` once in each half of every input cycle. It sweeps all 256 pairs of high and low counts, with varying offsets and start levels. Each sweep step is triggered by a `sync` placed in the middle of the previous pattern, and on the pairs that balance, correction is alternately on and off. Separate runs change the settings without `sync`, and enter bypass with the other settings at values that would otherwise change the output.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    parameter int CNT_W = 4;
    parameter int OFS_W = 4;

    typedef enum logic [1:0] {
        S_LOAD  = 2'd0,
        S_DELAY = 2'd1,
        S_HIGH  = 2'd2,
        S_LOW   = 2'd3
    } div_state_e;

    typedef struct packed {
        logic             bypass;
        logic             dcc_en;
        logic             start_hi;
        logic [OFS_W-1:0] ofs;
        logic [CNT_W-1:0] n;
        logic [CNT_W-1:0] m;
    } div_cfg_t;
endpackage

// File: rtl/clkdiv_cfg_latch.sv
module clkdiv_cfg_latch
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cap,
    input  div_cfg_t cfg_in,
    output div_cfg_t cfg_q,
    output div_cfg_t cfg_eff
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cap) begin
            cfg_q <= cfg_in;
        end
    end

    // settings seen by the sequencer at this edge
    assign cfg_eff = cap ? cfg_in : cfg_q;
endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [CNT_W-1:0] eff_n,
    input  logic [CNT_W-1:0] eff_m,
    input  logic [OFS_W-1:0] eff_ofs,
    input  logic             eff_start_hi,
    output div_state_e       st,
    output logic [CNT_W-1:0] ph_cnt,
    output logic [OFS_W-1:0] dly_cnt,
    output logic             raw_q
);
    div_state_e       st_d;
    logic [CNT_W-1:0] cnt_d;
    logic [OFS_W-1:0] dly_d;
    div_state_e       first_st;
    logic [CNT_W-1:0] first_cnt;

    assign first_st  = eff_start_hi ? S_HIGH : S_LOW;
    assign first_cnt = eff_start_hi ? eff_n : eff_m;

    always_comb begin
        st_d  = st;
        cnt_d = ph_cnt;
        dly_d = dly_cnt;
        if (cap) begin
            if (eff_ofs == '0) begin
                st_d  = first_st;
                cnt_d = first_cnt;
            end else begin
                st_d  = S_DELAY;
                dly_d = eff_ofs - 1'b1;
            end
        end else begin
            unique case (st)
                S_LOAD: begin
                    st_d = S_LOAD;
                end
                S_DELAY: begin
                    if (dly_cnt == '0) begin
                        st_d  = first_st;
                        cnt_d = first_cnt;
                    end else begin
                        dly_d = dly_cnt - 1'b1;
                    end
                end
                S_HIGH: begin
                    if (ph_cnt == '0) begin
                        st_d  = S_LOW;
                        cnt_d = eff_m;
                    end else begin
                        cnt_d = ph_cnt - 1'b1;
                    end
                end
                S_LOW: begin
                    if (ph_cnt == '0) begin
                        st_d  = S_HIGH;
                        cnt_d = eff_n;
                    end else begin
                        cnt_d = ph_cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_LOAD;
            ph_cnt  <= '0;
            dly_cnt <= '0;
        end else begin
            st      <= st_d;
            ph_cnt  <= cnt_d;
            dly_cnt <= dly_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else begin
            unique case (st_d)
                S_LOAD:  raw_q <= 1'b0;
                S_DELAY: raw_q <= !eff_start_hi;
                S_HIGH:  raw_q <= 1'b1;
                S_LOW:   raw_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/clkdiv_dcc.sv
module clkdiv_dcc
    import clkdiv_pkg::*;
#(
    parameter bit HAS_DCC = 1'b1
)(
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             bypass,
    input  logic             dcc_en,
    input  logic [CNT_W-1:0] n,
    input  logic [CNT_W-1:0] m,
    output logic             clk_out
);
    logic shaped;

    generate
        if (HAS_DCC) begin : g_dcc
            logic             raw_neg;
            logic [CNT_W:0]   n_plus;
            logic             act;

            assign n_plus = {1'b0, n} + 1'b1;
            assign act    = dcc_en && ({1'b0, m} == n_plus);

            always_ff @(negedge clk_in or negedge rst_n) begin
                if (!rst_n) raw_neg <= 1'b0;
                else        raw_neg <= raw;
            end

            assign shaped = raw | (act & raw_neg);
        end else begin : g_plain
            logic unused_ok;
            assign unused_ok = ^{dcc_en, n, m};
            assign shaped    = raw;
        end
    endgenerate

    assign clk_out = bypass ? clk_in : shaped;
endmodule

// File: rtl/clkdiv_duty.sv
module clkdiv_duty
    import clkdiv_pkg::*;
#(
    parameter bit HAS_DCC = 1'b1
)(
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic             bypass,
    input  logic             dcc_en,
    input  logic [OFS_W-1:0] phase_ofs,
    input  logic             start_hi,
    output logic             clk_out
);
    div_cfg_t         cfg_in, cfg_q, cfg_eff;
    div_state_e       st;
    logic [CNT_W-1:0] ph_cnt;
    logic [OFS_W-1:0] dly_cnt;
    logic             raw_q;
    logic             cap;

    assign cfg_in = '{bypass: bypass, dcc_en: dcc_en, start_hi: start_hi,
                      ofs: phase_ofs, n: hi_cnt, m: lo_cnt};
    assign cap    = sync || (st == S_LOAD);

    clkdiv_cfg_latch u_cfg (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .cap     (cap),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .cfg_eff (cfg_eff)
    );

    clkdiv_fsm u_fsm (
        .clk          (clk_in),
        .rst_n        (rst_n),
        .cap          (cap),
        .eff_n        (cfg_eff.n),
        .eff_m        (cfg_eff.m),
        .eff_ofs      (cfg_eff.ofs),
        .eff_start_hi (cfg_eff.start_hi),
        .st           (st),
        .ph_cnt       (ph_cnt),
        .dly_cnt      (dly_cnt),
        .raw_q        (raw_q)
    );

    clkdiv_dcc #(.HAS_DCC(HAS_DCC)) u_dcc (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .raw     (raw_q),
        .bypass  (cfg_q.bypass),
        .dcc_en  (cfg_q.dcc_en),
        .n       (cfg_q.n),
        .m       (cfg_q.m),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
    import clkdiv_pkg::*;
(
    input logic             clk_in,
    input logic             rst_n,
    input logic             sync,
    input logic [OFS_W-1:0] phase_ofs,
    input logic             start_hi,
    input div_state_e       st,
    input logic [CNT_W-1:0] ph_cnt,
    input logic [OFS_W-1:0] dly_cnt,
    input div_cfg_t         cfg_q,
    input logic             raw_q
);
    // R1
    hi_len_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (st == S_HIGH && ph_cnt != '0 && !sync)
        |=> (st == S_HIGH && raw_q && ph_cnt == $past(ph_cnt) - {{(CNT_W-1){1'b0}}, 1'b1}));

    // R1
    fall_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (st == S_HIGH && ph_cnt == '0 && !sync)
        |=> (st == S_LOW && !raw_q && ph_cnt == cfg_q.m));

    // R1
    rise_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (st == S_LOW && ph_cnt == '0 && !sync)
        |=> (st == S_HIGH && raw_q && ph_cnt == cfg_q.n));

    // R5
    delay_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (st == S_DELAY && dly_cnt != '0 && !sync)
        |=> (st == S_DELAY && raw_q == !cfg_q.start_hi));

    // R6
    start_level_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (sync && phase_ofs == '0) |=> (raw_q == $past(start_hi)));

    // R7
    cfg_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!sync && st != S_LOAD) |=> $stable(cfg_q));
endmodule

bind clkdiv_duty clkdiv_chk u_chk (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .sync      (sync),
    .phase_ofs (phase_ofs),
    .start_hi  (start_hi),
    .st        (st),
    .ph_cnt    (ph_cnt),
    .dly_cnt   (dly_cnt),
    .cfg_q     (cfg_q),
    .raw_q     (raw_q)
);

// File: tb/sim_clkdiv_duty.sv
`timescale 1ns/1ps
module sim_clkdiv_duty;
    logic       clk_in = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic [3:0] hi_cnt = '0, lo_cnt = '0, phase_ofs = '0;
    logic       bypass = 1'b0, dcc_en = 1'b0, start_hi = 1'b0;
    logic       clk_out;
    int vectors = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk_in = ~clk_in;

    clkdiv_duty u0 (
        .clk_in(clk_in), .rst_n(rst_n), .sync(sync), .hi_cnt(hi_cnt),
        .lo_cnt(lo_cnt), .bypass(bypass), .dcc_en(dcc_en),
        .phase_ofs(phase_ofs), .start_hi(start_hi), .clk_out(clk_out)
    );

    function automatic logic raw_at(int k, int n, int m, int ofs, bit sh);
        int j;
        if (k < ofs) return !sh;
        j = (k - ofs) % (n + m + 2);
        if (sh) return (j < n + 1);
        return !(j < m + 1);
    endfunction

    task automatic chk(logic exp, string req, int k);
        vectors++;
        if (clk_out !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: clk_out=%b expected %b", req, k, clk_out, exp);
        end
    endtask

    task automatic setup(int n, int m, int ofs, bit sh, bit dcc, bit bp, bit do_sync);
        hi_cnt = 4'(n); lo_cnt = 4'(m); phase_ofs = 4'(ofs);
        start_hi = sh; dcc_en = dcc; bypass = bp;
        sync = do_sync;
    endtask

    // Call right after setup; next rising edge is the capture edge.
    task automatic track(int n, int m, int ofs, bit sh, bit dcc, bit bp,
                         int len, bit mess, string req);
        bit act;
        logic r, rp;
        act = dcc && (m == n + 1);
        @(posedge clk_in);
        #1.25 sync = 1'b0;
        #2.5;
        rp = raw_at(0, n, m, ofs, sh);
        chk(bp ? 1'b0 : rp, req, 0);
        for (int k = 1; k < len; k++) begin
            @(posedge clk_in);
            #1.25;
            r = raw_at(k, n, m, ofs, sh);
            chk(bp ? 1'b1 : (r | (act & rp)), req, k);
            if (mess && k == 2) begin
                // R7: no sync, so these must be ignored
                hi_cnt = 4'(m + 3); lo_cnt = 4'(n + 5); phase_ofs = 4'd9;
                start_hi = !sh; dcc_en = !dcc; bypass = !bp;
            end
            #2.5;
            chk(bp ? 1'b0 : r, req, k);
            rp = r;
        end
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset holds output low
        setup(1, 2, 3, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk_in);
        #1.25 chk(1'b0, "R8", -1);
        // release: first edge after release captures (R5, R6)
        rst_n = 1'b1;
        track(1, 2, 3, 1'b1, 1'b0, 1'b0, 20, 1'b0, "R5");

        // R1 R3 R4 R6 R9: sweep every count pair, restarting mid-pattern via sync
        for (int n = 0; n < 16; n++) begin
            for (int m = 0; m < 16; m++) begin
                int ofs;
                bit sh, dcc;
                ofs = (n + 2 * m) % 16;
                sh  = bit'((n ^ m) & 1);
                dcc = (m == n + 1) ? bit'((n & 1) == 0) : 1'b1;
                setup(n, m, ofs, sh, dcc, 1'b0, 1'b1);
                track(n, m, ofs, sh, dcc, 1'b0, ofs + n + m + 2 + (n + m + 2) / 2 + 3,
                      1'b0, (m == n + 1) ? (dcc ? "R3" : "R4") : "R1");
            end
        end

        // R7: settings changed without sync are ignored
        setup(2, 4, 1, 1'b0, 1'b1, 1'b0, 1'b1);
        track(2, 4, 1, 1'b0, 1'b1, 1'b0, 30, 1'b1, "R7");
        setup(3, 4, 0, 1'b1, 1'b1, 1'b0, 1'b1);
        track(3, 4, 0, 1'b1, 1'b1, 1'b0, 30, 1'b1, "R7");

        // R2: bypass ignores correction, offset and start level
        setup(2, 3, 7, 1'b0, 1'b1, 1'b1, 1'b1);
        track(2, 3, 7, 1'b0, 1'b1, 1'b1, 16, 1'b0, "R2");
        // R9: sync leaves bypass and restarts division
        setup(4, 1, 2, 1'b1, 1'b0, 1'b0, 1'b1);
        track(4, 1, 2, 1'b1, 1'b0, 1'b0, 20, 1'b0, "R9");

        // R8: asynchronous reset mid-cycle
        @(posedge clk_in);
        #0.5 setup(4, 1, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        #0.1 rst_n = 1'b0;
        #0.5 chk(1'b0, "R8", -2);
        #1.0 chk(1'b0, "R8", -3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule